// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block supervises a programmable clock generator. Software reaches it through a small register port with an address, write data, a write strobe and combinational read data, which stands in for a two-wire management bus. The port exposes a control byte and a frequency-select register. The frequency-select value drives the synthesizer.

When the watchdog is enabled, a frequency change arms a down-counter. Software is expected to confirm that the new clock works by clearing the enable bit before the count runs out. If the count expires first, the block does three things. It emits a system reset pulse, forces a fixed recovery frequency code, and locks the frequency register. The lock holds until software clears the enable bit. Independently of the watchdog, software may ask for a reset pulse on every accepted frequency change.

Top module: `freq_watchdog`

## Requirements
- R1: After reset, the control byte (address 0) and the frequency register (address 1) both read 0. `sys_rst_o` and `locked_o` are low.
- R2: The control byte places the reset-on-change enable at bit 3, the timeout status at bit 2 and the watchdog enable at bit 1. Bit 1 and bit 3 read back as written. Bit 0 and bits 7..4 always read 0. Addresses 2 and 3 read 0, and writes to them change nothing.
- R3: The status bit is set by a timeout. Writing 1 to bit 2 clears it, and writing 0 to bit 2 leaves it unchanged. The status survives an unlock.
- R4: With the watchdog disabled, a write to address 1 stores the low FREQ_W bits and never causes a timeout.
- R5: With the watchdog enabled, a write of a new value to the frequency register arms the timer. The timeout takes effect at the TIMEOUT-th rising edge after the write edge. At that edge the status is set, the frequency output becomes RECOV_CODE, `locked_o` rises, and a `sys_rst_o` pulse of RST_W cycles begins.
- R6: A write of the value already held in the frequency register is not a change and does not arm the timer.
- R7: A new frequency change while the timer is counting restarts the full TIMEOUT count.
- R8: Clearing the watchdog enable stops the timer and reloads it, so no timeout occurs. A later arm again waits the full TIMEOUT count.
- R9: While locked, writes to the frequency register are ignored. The frequency output holds RECOV_CODE and no reset pulse is produced.
- R10: Writing the control byte with bit 1 = 0 clears the lock, after which frequency writes are accepted again.
- R11: With bit 3 set, each accepted frequency change produces a `sys_rst_o` pulse of RST_W cycles, starting right after the write edge. With bit 3 clear, no pulse is produced.
- R12: Setting the watchdog enable without a frequency change does not start the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address (0 control, 1 frequency) |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 8 | Read data for addr_i |
| freq_sel_o | output | FREQ_W | Frequency code to the synthesizer |
| sys_rst_o | output | 1 | System reset pulse |
| locked_o | output | 1 | Recovery lock active |

## Verification
The bench aims at the exact timeout edge. A timer that is off by one cycle locks one cycle early or one cycle late, and the bench catches either case by sampling on both sides of the edge.

Several cases target how the timer is armed and stopped:
- A same-value frequency write must not arm the timer. A design that arms on any write would time out.
- A second change during the count must push the timeout back by the full TIMEOUT count. A design that does not restart the count would lock early.
- After the enable is cleared, a fresh arm must again wait the full count. A design that does not reload the counter would expire on a stale count.

Other cases target the lock and the status bit:
- Frequency writes made while locked must neither reach the output nor produce a reset pulse.
- The status bit must ignore a written 0. It must also survive an unlock, so a design that clears it together with the enable would fail.

// File: rtl/fcw_pkg.sv
package fcw_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_FREQ = 2'd1;
  localparam int B_RST_EN = 3;
  localparam int B_STATUS = 2;
  localparam int B_WD_EN  = 1;
endpackage

// File: rtl/fcw_regs.sv
module fcw_regs
  import fcw_pkg::*;
#(
  parameter int                FREQ_W     = 5,
  parameter logic [FREQ_W-1:0] FREQ_INIT  = '0,
  parameter logic [FREQ_W-1:0] RECOV_CODE = 5'h0A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic              locked_o,
  output logic              wd_en_o,
  output logic              wd_en_nxt_o,
  output logic              rst_en_o,
  output logic              chg_o
);
  logic ctrl_we, freq_we;
  logic rst_en_q, status_q, wd_en_q, locked_q;
  logic [FREQ_W-1:0] freq_q;

  always_comb begin
    ctrl_we     = we_i && (addr_i == A_CTRL);
    freq_we     = we_i && (addr_i == A_FREQ);
    wd_en_nxt_o = ctrl_we ? wdata_i[B_WD_EN] : wd_en_q;
    // timeout wins over a concurrent frequency write
    chg_o       = freq_we && !locked_q && !expire_i && (wdata_i[FREQ_W-1:0] != freq_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_en_q <= 1'b0;
      wd_en_q  <= 1'b0;
      status_q <= 1'b0;
      locked_q <= 1'b0;
      freq_q   <= FREQ_INIT;
    end else begin
      if (ctrl_we) begin
        rst_en_q <= wdata_i[B_RST_EN];
        wd_en_q  <= wdata_i[B_WD_EN];
      end
      if (expire_i)                          status_q <= 1'b1;
      else if (ctrl_we && wdata_i[B_STATUS]) status_q <= 1'b0;
      if (expire_i)                         locked_q <= 1'b1;
      else if (ctrl_we && !wdata_i[B_WD_EN]) locked_q <= 1'b0;
      if (expire_i)   freq_q <= RECOV_CODE;
      else if (chg_o) freq_q <= wdata_i[FREQ_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[B_RST_EN] = rst_en_q;
        rdata_o[B_STATUS] = status_q;
        rdata_o[B_WD_EN]  = wd_en_q;
      end
      A_FREQ:  rdata_o[FREQ_W-1:0] = freq_q;
      default: rdata_o = '0;
    endcase
  end

  assign freq_o   = freq_q;
  assign locked_o = locked_q;
  assign wd_en_o  = wd_en_q;
  assign rst_en_o = rst_en_q;
endmodule

// File: rtl/fcw_timer.sv
module fcw_timer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expire_o = run_q && en_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RELOAD;
      run_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= RELOAD;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= RELOAD;
      run_q <= 1'b1;
    end else if (expire_o) begin
      cnt_q <= RELOAD;
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/fcw_pulse.sv
module fcw_pulse #(
  parameter int WIDTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (trig_i)         cnt_q <= CNT_W'(WIDTH);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog
  import fcw_pkg::*;
#(
  parameter int                FREQ_W     = 5,
  parameter logic [FREQ_W-1:0] FREQ_INIT  = '0,
  parameter logic [FREQ_W-1:0] RECOV_CODE = 5'h0A,
  parameter int                TIMEOUT    = 16,
  parameter int                RST_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [FREQ_W-1:0] freq_sel_o,
  output logic              sys_rst_o,
  output logic              locked_o
);
  logic expire, chg, wd_en, wd_en_nxt, rst_en, rst_trig;

  fcw_regs #(
    .FREQ_W(FREQ_W), .FREQ_INIT(FREQ_INIT), .RECOV_CODE(RECOV_CODE)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .expire_i(expire), .rdata_o(rdata_o), .freq_o(freq_sel_o),
    .locked_o(locked_o), .wd_en_o(wd_en), .wd_en_nxt_o(wd_en_nxt),
    .rst_en_o(rst_en), .chg_o(chg)
  );

  fcw_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(wd_en_nxt), .start_i(chg),
    .expire_o(expire)
  );

  assign rst_trig = expire || (chg && rst_en);

  fcw_pulse #(.WIDTH(RST_W)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(rst_trig), .pulse_o(sys_rst_o)
  );
endmodule

// File: rtl/fcw_checker.sv
module fcw_checker #(
  parameter int                FREQ_W     = 5,
  parameter logic [FREQ_W-1:0] RECOV_CODE = 5'h0A
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FREQ_W-1:0] freq_sel_o,
  input logic              locked_o,
  input logic              sys_rst_o,
  input logic              wd_en,
  input logic              expire,
  input logic              chg,
  input logic              rst_en
);
  AST_LOCK_HOLDS_FREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> $stable(freq_sel_o)); // R9

  AST_LOCK_LOADS_RECOV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> (freq_sel_o == RECOV_CODE) && sys_rst_o); // R5

  AST_UNLOCK_NEEDS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> !wd_en); // R10

  AST_NO_LOCK_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en |=> !$rose(locked_o)); // R8

  AST_RST_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(expire || (chg && rst_en))); // R11
endmodule

bind freq_watchdog fcw_checker #(.FREQ_W(FREQ_W), .RECOV_CODE(RECOV_CODE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .freq_sel_o(freq_sel_o), .locked_o(locked_o),
  .sys_rst_o(sys_rst_o), .wd_en(wd_en), .expire(expire), .chg(chg), .rst_en(rst_en)
);

// File: tb/sim_freq_watchdog.sv
`timescale 1ns/1ps
module sim_freq_watchdog;
  localparam int FREQ_W = 5;
  localparam logic [FREQ_W-1:0] RECOV = 5'h0A;
  localparam int T  = 16;
  localparam int RW = 4;
  localparam int NV = 8;
  // {we, addr, wdata, expected read of addr afterwards}
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h00, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h00},
    {1'b1, 2'd0, 8'h08, 8'h08},
    {1'b1, 2'd0, 8'hF5, 8'h00},
    {1'b1, 2'd1, 8'h13, 8'h13},
    {1'b1, 2'd1, 8'hFF, 8'h1F},
    {1'b0, 2'd2, 8'h00, 8'h00},
    {1'b1, 2'd3, 8'hFF, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [FREQ_W-1:0] freq;
  logic sys_rst, locked;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  freq_watchdog #(.FREQ_W(FREQ_W), .RECOV_CODE(RECOV), .TIMEOUT(T), .RST_W(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .freq_sel_o(freq), .sys_rst_o(sys_rst), .locked_o(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count high cycles of sys_rst over RW samples, then expect low
  task automatic chk_pulse(input string req, input int exp_hi);
    int hi = 0;
    for (int i = 0; i < RW; i++) begin
      if (sys_rst) hi++;
      @(negedge clk);
    end
    chk(req, hi, exp_hi);
    chk(req, int'(sys_rst), 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    #35 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(sys_rst), 0);
    chk("R1", int'(locked), 0);
    chk("R1", int'(freq), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], r);
      chk(i < 2 ? "R1" : (i < 4 || i > 5) ? "R2" : "R4", int'(r), int'(VEC[i][7:0]));
    end
    rd(2'd1, r);
    chk("R2", int'(r), 8'h1F);
    wait_cyc(T + 4);
    chk("R4", int'(locked), 0);

    // R5: timeout on exact edge
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h03);
    wait_cyc(T - 1);
    chk("R5", int'(locked), 0);
    rd(2'd0, r);
    chk("R5", int'(r), 8'h02);
    wait_cyc(1);
    chk("R5", int'(locked), 1);
    chk("R5", int'(freq), int'(RECOV));
    rd(2'd0, r);
    chk("R5", int'(r), 8'h06);
    chk_pulse("R5", RW);

    // R9: locked ignores frequency writes, even with reset-on-change set
    wr(2'd0, 8'h0A);
    rd(2'd0, r);
    chk("R3", int'(r), 8'h0E);
    wr(2'd1, 8'h07);
    chk("R9", int'(sys_rst), 0);
    chk("R9", int'(freq), int'(RECOV));
    rd(2'd1, r);
    chk("R9", int'(r), int'(RECOV));

    // R3: write 1 clears status, lock stays
    wr(2'd0, 8'h0E);
    rd(2'd0, r);
    chk("R3", int'(r), 8'h0A);
    chk("R3", int'(locked), 1);

    // R10 unlock, R11 pulse on accepted change
    wr(2'd0, 8'h08);
    chk("R10", int'(locked), 0);
    wr(2'd1, 8'h07);
    chk("R10", int'(freq), 7);
    chk_pulse("R11", RW);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h09);
    chk("R11", int'(sys_rst), 0);

    // R6: same value does not arm
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h09);
    wait_cyc(T + 3);
    chk("R6", int'(locked), 0);

    // R7: restart during count
    wr(2'd1, 8'h04);
    wait_cyc(T - 3);
    wr(2'd1, 8'h05);
    wait_cyc(T - 1);
    chk("R7", int'(locked), 0);
    wait_cyc(1);
    chk("R7", int'(locked), 1);
    chk("R7", int'(freq), int'(RECOV));
    wr(2'd0, 8'h00);
    rd(2'd0, r);
    chk("R3", int'(r), 8'h04);
    wr(2'd0, 8'h04);
    rd(2'd0, r);
    chk("R3", int'(r), 8'h00);

    // R8: stop before expiry, then full count on re-arm
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h06);
    wait_cyc(T - 2);
    wr(2'd0, 8'h00);
    wait_cyc(T + 2);
    chk("R8", int'(locked), 0);
    rd(2'd0, r);
    chk("R8", int'(r), 8'h00);
    chk("R8", int'(freq), 6);

    // R12: enable alone does not arm
    wr(2'd0, 8'h02);
    wait_cyc(T + 3);
    chk("R12", int'(locked), 0);
    wr(2'd1, 8'h08);
    wait_cyc(T - 1);
    chk("R8", int'(locked), 0);
    wait_cyc(1);
    chk("R8", int'(locked), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule